// File: doc/BRIEF.md
# Two-Wire Slave Port with 16-Bit Internal Addressing

This block lets a host on a two-wire serial bus read and write a 16-bit internal address space. It answers to one fixed 7-bit device address. In a write transaction, the first two bytes after the device address set an internal pointer, high byte first. Each later byte is stored at the pointer, and the pointer then moves up by one. A read transaction does not carry an address. It starts at whatever the pointer holds, so a host first runs a short write with only the two pointer bytes, then issues a repeated or fresh start with the read flag.

Toward the chip the block drives a plain memory port. An address, a write-data byte and a one-cycle write strobe form the write side. A one-cycle read strobe with data returned on the following clock forms the read side. A combinational decoder classifies the pointer into one of four regions: scratch RAM, character ROM, control registers, or unmapped. Writes that land in ROM or unmapped space are acknowledged on the bus but never strobed. Reads of unmapped space return zero without touching the port. A write that sets bit 0 of the last control register produces a one-cycle reset pulse for the rest of the chip.

SCL and SDA are sampled by the system clock through a synchronizer. The block drives SDA only through an open-drain enable.

Top module: `i2c_mapped_slave`

## Requirements
- R1: Only device address 0x5D (byte 0xBA with write flag, 0xBB with read flag) is acknowledged. Any other address gets no acknowledge, the SDA enable stays off, and the rest of that transaction is ignored.
- R2: In a write, the two bytes after the device address load the pointer, high byte first. Every bit on the wire is taken most significant bit first. Each following byte appears on mem_wdata with the pointer on mem_addr during a one-cycle mem_we.
- R3: The pointer advances by one after every data byte, including dropped ones, and wraps from 0xFFFF to 0x0000.
- R4: The pointer persists across transactions. A read transaction starts at the stored pointer, and every byte sent to the host advances it by one.
- R5: Read bytes are sent MSB first. A host acknowledge (SDA low) requests the next byte. A host non-acknowledge ends the stream and the block releases SDA.
- R6: mem_region encodes the pointer: 0 for 0x0000–0x03FF (RAM), 1 for 0x0800–0x3FFF (ROM), 2 for 0x4000–0x403F (registers), 3 for everything else.
- R7: Bytes written to region 1 or 3 are acknowledged but produce no mem_we.
- R8: Reads in region 3 return 0x00 and produce no mem_re.
- R9: A data byte with bit 0 set, written to 0x403F, gives a one-cycle soft_rst pulse in the same cycle as its mem_we. If bit 0 is clear, no pulse occurs.
- R10: The SDA enable changes only while SCL is low, and mem_we and mem_re are never high together.
- R11: After reset, SDA is released, both strobes and soft_rst are low, and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high |
| mem_addr | output | 16 | Internal pointer |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the clock after mem_re |
| mem_region | output | 2 | Region code of mem_addr |
| soft_rst | output | 1 | One-cycle reset pulse for the chip |

## Verification
A sweep of all 128 device addresses shows that the address compare accepts exactly one value and that a rejected transaction makes no access. Burst writes and burst reads that straddle the RAM end, the ROM end and the 0xFFFF wrap show whether the pointer advances on dropped bytes and whether the region gate follows the moving pointer inside one burst. Write-then-read pairs that use a fresh read transaction or a read ending in non-acknowledge tell apart a stored pointer from one that resets per transaction. The soft-reset byte is tried with bit 0 set, with bit 0 clear, and with other bits set, to isolate the one bit that matters.

// File: rtl/i2c_mapped_pkg.sv
package i2c_mapped_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam logic [6:0] DEV_ID_DEF = 7'h5D;

    localparam logic [ADDR_W-1:0] RAM_LO  = 16'h0000;
    localparam logic [ADDR_W-1:0] RAM_HI  = 16'h03FF;
    localparam logic [ADDR_W-1:0] ROM_LO  = 16'h0800;
    localparam logic [ADDR_W-1:0] ROM_HI  = 16'h3FFF;
    localparam logic [ADDR_W-1:0] CTL_LO  = 16'h4000;
    localparam logic [ADDR_W-1:0] CTL_HI  = 16'h403F;
    localparam logic [ADDR_W-1:0] KICK_AT = 16'h403F;

    typedef enum logic [1:0] {
        RGN_RAM  = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_CTL  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK
    } link_state_e;

    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_evt_t;

    function automatic region_e map_region(input logic [ADDR_W-1:0] a);
        if (a >= RAM_LO && a <= RAM_HI)      return RGN_RAM;
        else if (a >= ROM_LO && a <= ROM_HI) return RGN_ROM;
        else if (a >= CTL_LO && a <= CTL_HI) return RGN_CTL;
        else                                 return RGN_NONE;
    endfunction

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync
    import i2c_mapped_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_sh, sda_sh;
    logic         scl_q, sda_q;
    logic         scl_l, sda_l;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[TOP-1:0], scl_i};
                    sda_sh <= {sda_sh[TOP-1:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_l = scl_sh[TOP];
    assign sda_l = sda_sh[TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_l;
            sda_q <= sda_l;
        end
    end

    always_comb begin
        evt.sda   = sda_l;
        evt.rise  = scl_l & ~scl_q;
        evt.fall  = ~scl_l & scl_q;
        evt.start = scl_l & scl_q & sda_q & ~sda_l;
        evt.stop  = scl_l & scl_q & ~sda_q & sda_l;
    end
endmodule

// File: rtl/i2c_region_map.sv
module i2c_region_map
    import i2c_mapped_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              writable
);
    always_comb begin
        region   = map_region(addr);
        writable = (region == RGN_RAM) || (region == RGN_CTL);
    end
endmodule

// File: rtl/i2c_mapped_slave.sv
module i2c_mapped_slave
    import i2c_mapped_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = DEV_ID_DEF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [1:0]        mem_region,
    output logic              soft_rst
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    line_evt_t         ev;
    region_e           region;
    logic              writable;

    link_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh, txbuf, txsh;
    logic [ADDR_W-1:0] ptr;
    logic [1:0]        bidx;
    logic              rw, acked, inc_q, fetch_q, fetch_d, fetch_none;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(ev)
    );

    i2c_region_map u_map (
        .addr(ptr), .region(region), .writable(writable)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            sh         <= '0;
            txbuf      <= '0;
            txsh       <= '0;
            ptr        <= '0;
            bidx       <= '0;
            rw         <= 1'b0;
            acked      <= 1'b0;
            inc_q      <= 1'b0;
            fetch_q    <= 1'b0;
            fetch_d    <= 1'b0;
            fetch_none <= 1'b0;
            sda_oe     <= 1'b0;
            mem_wdata  <= '0;
            mem_we     <= 1'b0;
            soft_rst   <= 1'b0;
        end else begin
            mem_we   <= 1'b0;
            soft_rst <= 1'b0;
            inc_q    <= 1'b0;
            fetch_q  <= 1'b0;
            fetch_d  <= fetch_q;
            if (fetch_d) txbuf <= fetch_none ? '0 : mem_rdata;
            if (inc_q)   ptr   <= ptr + 1'b1;

            if (ev.start) begin
                state  <= ST_DEV;
                cnt    <= '0;
                bidx   <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_RX: begin
                        if (ev.rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_DEV) begin
                                if (sh[BYTE_W-1:1] == DEV_ID) begin
                                    sda_oe <= 1'b1;
                                    rw     <= sh[0];
                                    state  <= ST_DACK;
                                    if (sh[0]) begin
                                        fetch_q    <= 1'b1;
                                        fetch_none <= (region == RGN_NONE);
                                    end
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_RACK;
                                unique case (bidx)
                                    2'd0: ptr[ADDR_W-1:BYTE_W] <= sh;
                                    2'd1: ptr[BYTE_W-1:0]      <= sh;
                                    default: begin
                                        mem_we    <= writable;
                                        mem_wdata <= sh;
                                        inc_q     <= 1'b1;
                                        soft_rst  <= (ptr == KICK_AT) && sh[0];
                                    end
                                endcase
                                if (bidx != 2'd2) bidx <= bidx + 1'b1;
                            end
                        end
                    end
                    ST_DACK, ST_RACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            if (state == ST_DACK && rw) begin
                                state  <= ST_TX;
                                txsh   <= txbuf;
                                sda_oe <= ~txbuf[BYTE_W-1];
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TACK;
                                acked  <= 1'b0;
                                ptr    <= ptr + 1'b1;
                            end else begin
                                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txsh[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_TACK: begin
                        if (ev.rise) begin
                            if (!ev.sda) begin
                                acked      <= 1'b1;
                                fetch_q    <= 1'b1;
                                fetch_none <= (region == RGN_NONE);
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (ev.fall && acked) begin
                            state  <= ST_TX;
                            cnt    <= '0;
                            txsh   <= txbuf;
                            sda_oe <= ~txbuf[BYTE_W-1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign mem_addr   = ptr;
    assign mem_re     = fetch_q & ~fetch_none;
    assign mem_region = region;
endmodule

// File: rtl/i2c_mapped_slave_chk.sv
module i2c_mapped_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        scl_i,
    input logic        sda_oe,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_we,
    input logic        mem_re,
    input logic [1:0]  mem_region,
    input logic        soft_rst
);
    // R7
    we_mapped_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_region == 2'd0 || mem_region == 2'd2));

    // R8
    re_mapped_chk: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> mem_region != 2'd3);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R10
    sda_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> mem_addr == $past(mem_addr) + 16'd1);

    // R9
    kick_with_write_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (mem_we && mem_addr == 16'h403F && mem_wdata[0]));

    // R9
    kick_single_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);
endmodule

bind i2c_mapped_slave i2c_mapped_slave_chk u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_region(mem_region), .soft_rst(soft_rst)
);

// File: tb/i2c_mapped_slave_test.sv
module i2c_mapped_slave_test;
    localparam int HP = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    wire         sda_line;
    logic        sda_oe;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re, soft_rst;
    logic [7:0]  mem_rdata = 8'h00;
    logic [1:0]  mem_region;

    int checks = 0;
    int errors = 0;
    int n_we = 0, n_soft = 0, bad_re = 0, bad_ex = 0, bad_scl = 0;
    bit done = 0;
    logic oe_prev = 1'b0;
    logic [7:0] ram_m [0:1023];
    logic [7:0] ctl_m [0:63];
    logic [7:0] rbuf  [0:15];

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_mapped_slave uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_region(mem_region), .soft_rst(soft_rst)
    );

    function automatic int exp_region(input logic [15:0] a);
        if (a < 16'h0400) return 0;
        if (a >= 16'h0800 && a < 16'h4000) return 1;
        if (a >= 16'h4000 && a < 16'h4040) return 2;
        return 3;
    endfunction

    function automatic logic [7:0] rom_val(input logic [15:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8];
    endfunction

    function automatic logic [7:0] ram_init(input int i);
        return 8'(i) ^ 8'hC3;
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) ram_m[i] = ram_init(i);
        for (int i = 0; i < 64; i++) ctl_m[i] = 8'h00;
    end

    always @(posedge clk) begin
        if (mem_re) begin
            case (exp_region(mem_addr))
                0: mem_rdata <= ram_m[mem_addr[9:0]];
                1: mem_rdata <= rom_val(mem_addr);
                2: mem_rdata <= ctl_m[mem_addr[5:0]];
                default: mem_rdata <= 8'hEE;
            endcase
        end
        if (mem_we) begin
            if (exp_region(mem_addr) == 0) ram_m[mem_addr[9:0]] <= mem_wdata;
            if (exp_region(mem_addr) == 2) ctl_m[mem_addr[5:0]] <= mem_wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) n_we++;
            if (soft_rst) n_soft++;
            if (mem_re && exp_region(mem_addr) == 3) bad_re++;
            if (mem_we && mem_re) bad_ex++;
            if (sda_oe != oe_prev && scl_m) bad_scl++;
            oe_prev = sda_oe;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic q();
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp();
            scl_m = 1'b1; hp();
            scl_m = 1'b0; q();
        end
        sda_m = 1'b1; hp();
        scl_m = 1'b1; repeat (HP / 2) @(negedge clk);
        ack = ~sda_line;
        repeat (HP / 2) @(negedge clk);
        scl_m = 1'b0; q();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp();
            scl_m = 1'b1; repeat (HP / 2) @(negedge clk);
            b[i] = sda_line;
            repeat (HP / 2) @(negedge clk);
            scl_m = 1'b0; q();
        end
        sda_m = give_ack ? 1'b0 : 1'b1; hp();
        scl_m = 1'b1; hp();
        scl_m = 1'b0; q();
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [15:0] a, output int nacks);
        bit ack;
        nacks = 0;
        bus_start();
        send_byte(8'hBA, ack); if (!ack) nacks++;
        send_byte(a[15:8], ack); if (!ack) nacks++;
        send_byte(a[7:0], ack); if (!ack) nacks++;
    endtask

    task automatic wr_seq(input logic [15:0] a, input int n, input logic [7:0] first,
                          input logic [7:0] step, output int nacks);
        bit ack;
        set_ptr(a, nacks);
        for (int i = 0; i < n; i++) begin
            send_byte(8'(first + 8'(i) * step), ack);
            if (!ack) nacks++;
        end
        bus_stop();
    endtask

    task automatic rd_cont(input int n, output int nacks);
        bit ack;
        nacks = 0;
        bus_start();
        send_byte(8'hBB, ack); if (!ack) nacks++;
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic rd_seq(input logic [15:0] a, input int n, output int nacks);
        int k;
        set_ptr(a, nacks);
        rd_cont(n, k);
        nacks += k;
    endtask

    initial begin
        repeat (1000 * 190) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nk, we0, sf0;
        bit ack;
        logic [15:0] probe [0:11];
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        chk("R11 sda_oe", sda_oe, 0);
        chk("R11 strobes", {mem_we, mem_re, soft_rst}, 0);
        chk("R11 ptr", mem_addr, 0);

        // R1: device address sweep with write flag
        for (int a = 0; a < 128; a++) begin
            we0 = n_we;
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            bus_stop();
            chk($sformatf("R1 ack dev %0h", a), ack, (a == 'h5D) ? 1 : 0);
        end
        // R1: wrong address with read flag makes no access and never drives
        bus_start();
        send_byte(8'hB9, ack);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
        chk("R1 read-flag mismatch ack", ack, 0);
        chk("R1 mismatch data all ones", rbuf[0], 8'hFF);

        // R2 R3 R7: burst across RAM end, 4 bytes fall into unmapped space
        we0 = n_we;
        wr_seq(16'h03F8, 12, 8'h30, 8'h01, nk);
        chk("R7 all bytes acked", nk, 0);
        chk("R7 strobes only in RAM", n_we - we0, 8);
        chk("R3 ptr after burst", mem_addr, 16'h0404);

        // R4 R8: read across the same boundary
        rd_seq(16'h03FC, 8, nk);
        chk("R4 read acks", nk, 0);
        for (int i = 0; i < 8; i++)
            chk($sformatf("R8 R4 byte %0d", i), rbuf[i], (i < 4) ? 8'h34 + i : 8'h00);
        chk("R4 ptr after read", mem_addr, 16'h0404);

        // R5: ROM burst, MSB-first bytes
        rd_seq(16'h0FF8, 16, nk);
        for (int i = 0; i < 16; i++)
            chk($sformatf("R5 rom byte %0d", i), rbuf[i], rom_val(16'h0FF8 + 16'(i)));

        // R7: writes into ROM are dropped
        we0 = n_we;
        wr_seq(16'h0900, 3, 8'h55, 8'h11, nk);
        chk("R7 rom write acked", nk, 0);
        chk("R7 rom write no strobe", n_we - we0, 0);
        rd_seq(16'h0900, 3, nk);
        for (int i = 0; i < 3; i++)
            chk($sformatf("R7 rom unchanged %0d", i), rbuf[i], rom_val(16'h0900 + 16'(i)));

        // R6: region code at the map edges
        probe[0] = 16'h0000; probe[1] = 16'h03FF; probe[2]  = 16'h0400; probe[3]  = 16'h07FF;
        probe[4] = 16'h0800; probe[5] = 16'h3FFF; probe[6]  = 16'h4000; probe[7]  = 16'h403F;
        probe[8] = 16'h4040; probe[9] = 16'h7FFF; probe[10] = 16'h8000; probe[11] = 16'hFFFF;
        for (int i = 0; i < 12; i++) begin
            set_ptr(probe[i], nk);
            bus_stop();
            chk($sformatf("R6 region %0h", probe[i]), mem_region, exp_region(probe[i]));
        end

        // R2: control registers write then read
        wr_seq(16'h4000, 4, 8'h11, 8'h11, nk);
        rd_seq(16'h4000, 4, nk);
        for (int i = 0; i < 4; i++)
            chk($sformatf("R2 ctl byte %0d", i), rbuf[i], 8'h11 * (i + 1));

        // R9: soft reset byte
        sf0 = n_soft;
        wr_seq(16'h403F, 1, 8'h01, 8'h00, nk);
        chk("R9 bit0 set pulses once", n_soft - sf0, 1);
        sf0 = n_soft;
        wr_seq(16'h403F, 1, 8'h02, 8'h00, nk);
        chk("R9 bit0 clear no pulse", n_soft - sf0, 0);
        sf0 = n_soft;
        wr_seq(16'h403F, 1, 8'h81, 8'h00, nk);
        chk("R9 other bits ignored", n_soft - sf0, 1);
        sf0 = n_soft;
        wr_seq(16'h403E, 1, 8'h01, 8'h00, nk);
        chk("R9 neighbour no pulse", n_soft - sf0, 0);

        // R3: wrap from 0xFFFF to 0x0000
        we0 = n_we;
        wr_seq(16'hFFFF, 2, 8'hA1, 8'h11, nk);
        chk("R3 wrap single strobe", n_we - we0, 1);

        // R5 R4: read ending in non-acknowledge, then continue from stored pointer
        rd_seq(16'h0000, 3, nk);
        chk("R3 wrapped byte", rbuf[0], 8'hB2);
        chk("R5 byte 1", rbuf[1], ram_init(1));
        chk("R5 byte 2", rbuf[2], ram_init(2));
        chk("R5 sda released after nack", sda_oe, 0);
        rd_cont(2, nk);
        chk("R4 continue ack", nk, 0);
        chk("R4 continue byte 3", rbuf[0], ram_init(3));
        chk("R4 continue byte 4", rbuf[1], ram_init(4));

        // R8 R10: monitors
        chk("R8 no read strobe in unmapped space", bad_re, 0);
        chk("R10 strobes exclusive", bad_ex, 0);
        chk("R10 sda changes with scl low", bad_scl, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule